// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and drives two request outputs to a processor: a normal request and a fast request. Both outputs look at one shared raw level vector. Each output has its own enable mask. Software changes a mask only through a pair of word addresses, one that sets the bits written as one and one that clears them, so no read-modify-write is ever needed.

Line 0 can also be raised by software. A set address and a clear address drive a separate software flag, and that flag is ORed with hardware line 0. The input lines are registered once, and both outputs are decoded combinationally from the registered level and the mask registers. Controllers can be cascaded by wiring the normal output of a child instance to one input line of a parent. The register bus is a plain single-cycle word interface. Reads are combinational and writes take effect at the clock edge.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset both enable masks and the software flag are zero, so `irqOut` and `fiqOut` stay low whatever levels are on `lineIn`.
- R2: Each input line is sampled on every clock edge. Word index 1 and word index 9 both return the raw level vector, valid from the edge after the line changes.
- R3: A write to word index 2 ORs the written data into the normal enable mask. A write to index 3 clears the mask bits that are 1 in the data. A read of index 2 returns the mask.
- R4: A write to word index 10 ORs the written data into the fast enable mask. A write to index 11 clears the mask bits that are 1 in the data. A read of index 10 returns the mask.
- R5: `irqOut` is high exactly when the level AND the normal mask is non-zero, and a read of index 0 returns that AND. A mask write shows on `irqOut` in the cycle after the write.
- R6: `fiqOut` is high exactly when the level AND the fast mask is non-zero, and a read of index 8 returns that AND.
- R7: A write to index 4 with data bit 0 set raises the software flag. A write to index 5 with data bit 0 set lowers it. These writes do nothing when data bit 0 is clear. Level bit 0 is hardware line 0 OR the flag, and a read of index 4 returns level bit 0 in data bit 0 with all other bits zero.
- R8: Reads of the clear-only indices 3, 5 and 11, and of every index not listed above, return zero.
- R9: Writes to the status indices 0, 1, 8 and 9 change neither mask nor the software flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busIdx | input | IDX_W | Word index of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| lineIn | input | NUM_LINES | Level-sensitive interrupt inputs |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its defaults: 32 lines, a 32-bit data word and a 4-bit word index. With these values the top line (bit 31), an all-ones mask and every index from 0 to 15 can be reached, including the unused ones. The chosen patterns drive the two masks into separate bit ranges, so one output can be high while the other is low. Line 0 is driven from hardware and from software at the same time, which shows that clearing the software flag does not hide a live hardware level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word indices whose position is decoded by software drivers
  localparam int unsigned IDX_IRQ_STATUS = 0;
  localparam int unsigned IDX_RAW_A      = 1;
  localparam int unsigned IDX_IRQ_SET    = 2;
  localparam int unsigned IDX_IRQ_CLR    = 3;
  localparam int unsigned IDX_SOFT_SET   = 4;
  localparam int unsigned IDX_SOFT_CLR   = 5;
  localparam int unsigned IDX_FIQ_STATUS = 8;
  localparam int unsigned IDX_RAW_B      = 9;
  localparam int unsigned IDX_FIQ_SET    = 10;
  localparam int unsigned IDX_FIQ_CLR    = 11;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IRQ_STATUS,
    RD_RAW,
    RD_IRQ_MASK,
    RD_SOFT,
    RD_FIQ_STATUS,
    RD_FIQ_MASK
  } rdSel_e;

  typedef struct packed {
    logic   irqSet;
    logic   irqClr;
    logic   fiqSet;
    logic   fiqClr;
    logic   softSet;
    logic   softClr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] busIdx,
  input  logic             wdataBit0,
  output strobes_t         strobes
);

  logic doWrite;
  logic doRead;

  assign doWrite = busSel && busWrite;
  assign doRead  = busSel && !busWrite;

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_ZERO;
    if (doWrite) begin
      unique case (busIdx)
        IDX_W'(IDX_IRQ_SET):  strobes.irqSet  = 1'b1;
        IDX_W'(IDX_IRQ_CLR):  strobes.irqClr  = 1'b1;
        IDX_W'(IDX_FIQ_SET):  strobes.fiqSet  = 1'b1;
        IDX_W'(IDX_FIQ_CLR):  strobes.fiqClr  = 1'b1;
        IDX_W'(IDX_SOFT_SET): strobes.softSet = wdataBit0;
        IDX_W'(IDX_SOFT_CLR): strobes.softClr = wdataBit0;
        default: ;
      endcase
    end
    if (doRead) begin
      unique case (busIdx)
        IDX_W'(IDX_IRQ_STATUS): strobes.rdSel = RD_IRQ_STATUS;
        IDX_W'(IDX_RAW_A):      strobes.rdSel = RD_RAW;
        IDX_W'(IDX_RAW_B):      strobes.rdSel = RD_RAW;
        IDX_W'(IDX_IRQ_SET):    strobes.rdSel = RD_IRQ_MASK;
        IDX_W'(IDX_SOFT_SET):   strobes.rdSel = RD_SOFT;
        IDX_W'(IDX_FIQ_STATUS): strobes.rdSel = RD_FIQ_STATUS;
        IDX_W'(IDX_FIQ_SET):    strobes.rdSel = RD_FIQ_MASK;
        default:                strobes.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [DATA_W-1:0]    busRdata,
  output logic [NUM_LINES-1:0] effLevel,
  output logic [NUM_LINES-1:0] irqEn,
  output logic [NUM_LINES-1:0] fiqEn,
  output logic                 irqOut,
  output logic                 fiqOut
);

  logic [NUM_LINES-1:0] lineQ;
  logic                 softQ;
  logic [NUM_LINES-1:0] wMask;
  logic [NUM_LINES-1:0] irqHit;
  logic [NUM_LINES-1:0] fiqHit;

  assign wMask = busWdata[NUM_LINES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= '0;
      softQ <= 1'b0;
      irqEn <= '0;
      fiqEn <= '0;
    end else begin
      lineQ <= lineIn;
      if (strobes.softSet)      softQ <= 1'b1;
      else if (strobes.softClr) softQ <= 1'b0;
      if (strobes.irqSet)       irqEn <= irqEn | wMask;
      else if (strobes.irqClr)  irqEn <= irqEn & ~wMask;
      if (strobes.fiqSet)       fiqEn <= fiqEn | wMask;
      else if (strobes.fiqClr)  fiqEn <= fiqEn & ~wMask;
    end
  end

  // Per-line gating of the shared level by each mask
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == 0) begin : g_soft
      assign effLevel[i] = lineQ[i] | softQ;
    end else begin : g_hw
      assign effLevel[i] = lineQ[i];
    end
    assign irqHit[i] = effLevel[i] & irqEn[i];
    assign fiqHit[i] = effLevel[i] & fiqEn[i];
  end

  assign irqOut = |irqHit;
  assign fiqOut = |fiqHit;

  always_comb begin
    unique case (strobes.rdSel)
      RD_IRQ_STATUS: busRdata = DATA_W'(irqHit);
      RD_RAW:        busRdata = DATA_W'(effLevel);
      RD_IRQ_MASK:   busRdata = DATA_W'(irqEn);
      RD_SOFT:       busRdata = DATA_W'(effLevel[0]);
      RD_FIQ_STATUS: busRdata = DATA_W'(fiqHit);
      RD_FIQ_MASK:   busRdata = DATA_W'(fiqEn);
      default:       busRdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [IDX_W-1:0]     busIdx,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic                 irqOut,
  output logic                 fiqOut
);

  strobes_t             strobes;
  logic [NUM_LINES-1:0] effLevel;
  logic [NUM_LINES-1:0] irqEn;
  logic [NUM_LINES-1:0] fiqEn;

  irqc_decode #(.IDX_W(IDX_W)) u_decode (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busIdx    (busIdx),
    .wdataBit0 (busWdata[0]),
    .strobes   (strobes)
  );

  irqc_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .lineIn   (lineIn),
    .busRdata (busRdata),
    .effLevel (effLevel),
    .irqEn    (irqEn),
    .fiqEn    (fiqEn),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [IDX_W-1:0]     busIdx,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    busRdata,
  input logic [NUM_LINES-1:0] effLevel,
  input logic [NUM_LINES-1:0] irqEn,
  input logic [NUM_LINES-1:0] fiqEn,
  input logic                 irqOut,
  input logic                 fiqOut
);

  logic [NUM_LINES-1:0] allOnes;
  assign allOnes = '1;

  a_r1_masks_clear_at_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (irqEn == '0) && (fiqEn == '0) && !irqOut && !fiqOut);

  a_r3_set_bits_stick: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busIdx == IDX_W'(2))
      |=> ((irqEn & $past(busWdata[NUM_LINES-1:0])) == $past(busWdata[NUM_LINES-1:0])));

  a_r4_set_bits_stick: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busIdx == IDX_W'(10))
      |=> ((fiqEn & $past(busWdata[NUM_LINES-1:0])) == $past(busWdata[NUM_LINES-1:0])));

  a_r5_clear_all_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busIdx == IDX_W'(3) && busWdata[NUM_LINES-1:0] == allOnes)
      |=> !irqOut);

  a_r6_clear_all_drops_fiq: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busIdx == IDX_W'(11) && busWdata[NUM_LINES-1:0] == allOnes)
      |=> !fiqOut);

  a_r7_soft_raises_line0: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busIdx == IDX_W'(4) && busWdata[0]) |=> effLevel[0]);

  a_r8_clear_only_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite &&
     (busIdx == IDX_W'(3) || busIdx == IDX_W'(5) || busIdx == IDX_W'(11)))
      |-> (busRdata == '0));

  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite &&
     (busIdx == IDX_W'(0) || busIdx == IDX_W'(1) || busIdx == IDX_W'(8) || busIdx == IDX_W'(9)))
      |=> $stable(irqEn) && $stable(fiqEn));

endmodule

bind dual_irq_ctrl irqc_checker #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk (.*);

// File: tb/dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_irq_ctrl_test;

  localparam int unsigned NL = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [IW-1:0] busIdx = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NL-1:0] lineIn = '0;
  logic          irqOut;
  logic          fiqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_irq_ctrl #(.NUM_LINES(NL), .DATA_W(DW), .IDX_W(IW)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input int idx, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busIdx = IW'(idx); busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input int idx, output logic [31:0] val);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busIdx = IW'(idx);
    #1 val = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setLines(input logic [31:0] v);
    @(negedge clk);
    lineIn = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRd(2, v); check("R1 irq mask after reset", v, 32'h0);
    busRd(10, v); check("R1 fiq mask after reset", v, 32'h0);
    setLines(32'hFFFF_FFFF);
    check("R1 irqOut quiet", 32'(irqOut), 32'h0);
    check("R1 fiqOut quiet", 32'(fiqOut), 32'h0);
  endtask

  task automatic testRaw();
    logic [31:0] v;
    setLines(32'hA5A5_0F0E);
    busRd(1, v); check("R2 raw at index 1", v, 32'hA5A5_0F0E);
    busRd(9, v); check("R2 raw at index 9", v, 32'hA5A5_0F0E);
  endtask

  task automatic testIrqMask();
    logic [31:0] v;
    busWr(2, 32'h0000_00F0);
    busWr(2, 32'h8000_0001);
    busRd(2, v); check("R3 set ORs", v, 32'h8000_00F1);
    busWr(3, 32'h0000_0030);
    busRd(2, v); check("R3 clear bits", v, 32'h8000_00C1);
  endtask

  task automatic testIrqOut();
    logic [31:0] v;
    setLines(32'h8000_0000);
    check("R5 irqOut high on bit 31", 32'(irqOut), 32'h1);
    busRd(0, v); check("R5 irq status", v, 32'h8000_0000);
    setLines(32'h0000_0F00);
    check("R5 irqOut low when unmasked lines only", 32'(irqOut), 32'h0);
    busRd(0, v); check("R5 irq status zero", v, 32'h0);
  endtask

  task automatic testFiq();
    logic [31:0] v;
    busWr(10, 32'h0000_0F00);
    check("R6 fiqOut next cycle after mask", 32'(fiqOut), 32'h1);
    check("R6 irqOut stays low", 32'(irqOut), 32'h0);
    busRd(10, v); check("R4 fiq mask", v, 32'h0000_0F00);
    busRd(8, v); check("R6 fiq status", v, 32'h0000_0F00);
    busWr(11, 32'hFFFF_FFFF);
    check("R6 fiqOut after clear", 32'(fiqOut), 32'h0);
    busRd(10, v); check("R4 fiq mask cleared", v, 32'h0);
  endtask

  task automatic testSoft();
    logic [31:0] v;
    setLines(32'h0);
    busWr(4, 32'h0000_0002);
    busRd(4, v); check("R7 set without bit0 ignored", v, 32'h0);
    busWr(4, 32'h0000_0001);
    busRd(4, v); check("R7 soft set", v, 32'h1);
    busRd(1, v); check("R7 soft in raw level", v, 32'h1);
    check("R7 soft drives irqOut", 32'(irqOut), 32'h1);
    busWr(5, 32'h0000_0000);
    busRd(4, v); check("R7 clear without bit0 ignored", v, 32'h1);
    setLines(32'h0000_0001);
    busWr(5, 32'h0000_0001);
    busRd(4, v); check("R7 hw line0 still seen", v, 32'h1);
    setLines(32'h0);
    busRd(4, v); check("R7 line0 low after both gone", v, 32'h0);
  endtask

  task automatic testZeroReads();
    logic [31:0] v;
    busWr(4, 32'h1);
    busWr(10, 32'h0000_00FF);
    busRd(3, v); check("R8 index 3 reads zero", v, 32'h0);
    busRd(5, v); check("R8 index 5 reads zero", v, 32'h0);
    busRd(11, v); check("R8 index 11 reads zero", v, 32'h0);
    busRd(6, v); check("R8 index 6 reads zero", v, 32'h0);
    busRd(15, v); check("R8 index 15 reads zero", v, 32'h0);
  endtask

  task automatic testStatusWrites();
    logic [31:0] v;
    busWr(0, 32'hFFFF_FFFF);
    busWr(1, 32'h0000_0000);
    busWr(8, 32'hFFFF_FFFF);
    busWr(9, 32'h0000_0000);
    busRd(2, v); check("R9 irq mask unchanged", v, 32'h8000_00C1);
    busRd(10, v); check("R9 fiq mask unchanged", v, 32'h0000_00FF);
    busRd(4, v); check("R9 soft flag unchanged", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRaw();
    testIrqMask();
    testIrqOut();
    testFiq();
    testSoft();
    testZeroReads();
    testStatusWrites();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule